// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block turns the threshold-comparator results of a three-rail supply supervisor into reset indications for the rest of a chip. Rail 0 is the main supply. Its reset output is active high. It is debounced, it can be forced by a manual request, and it is held asserted for a programmable timeout after the last cause of reset goes away. Rails 1 and 2 are auxiliary supplies. Their "good" flags are only resynchronized to the block clock and then passed straight out, with no filtering and no hold time.

The comparator inputs and the manual request are asynchronous, and each goes through a two-flop synchronizer. A two-bit select picks one of four timeout lengths, each set by a parameter. The select is sampled in the last cycle before a timeout begins, so changing it while a count is running has no effect on that count. Any new cause of reset that arrives during a timeout sends the block back to the held state. The count then starts again from zero once the cause clears.

Top module: `sup_rst_seq`

## Requirements
- R1: While `rst_ni` is low, `main_rst_o` is 1 and `aux_good_o` is 2'b00.
- R2: `aux_good_o[0]` follows `rail_good_i[1]` and `aux_good_o[1]` follows `rail_good_i[2]`. Each output shows the input value sampled two clock edges earlier, with no debounce, and the main reset output is not affected.
- R3: When `rail_good_i[0]` goes low and stays low, `main_rst_o` rises on the 7th rising clock edge after the change (2 synchronizer stages, 4 debounce samples, 1 output register).
- R4: A low pulse on `rail_good_i[0]` seen by fewer than 4 consecutive synchronized samples (3 clock cycles or less) leaves `main_rst_o` at 0.
- R5: A high level on `mr_i` makes `main_rst_o` rise on the 3rd rising edge after the change.
- R6: After `mr_i` returns low with the main rail good, `main_rst_o` stays high and falls on rising edge 2+L after the release, where L is the selected timeout in cycles.
- R7: After `rail_good_i[0]` returns high, and at power-up with the rail good when `rst_ni` is released, `main_rst_o` falls on rising edge 6+L after the change.
- R8: `tsel_i` = 0, 1, 2, 3 selects L = TMO0, TMO1, TMO2, TMO3. The defaults are 1024, 4096, 16384 and 65536 cycles.
- R9: A new manual request, or a new main-rail loss, during a running timeout keeps `main_rst_o` high. The timeout then counts again in full from the moment the new cause clears.
- R10: `tsel_i` is sampled in the last cycle before a timeout starts. A change of `tsel_i` during the count does not alter that count, and it applies to the next timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| rail_good_i | input | 3 | Comparator results, 1 = rail above its threshold; bit 0 is the main rail |
| mr_i | input | 1 | Asynchronous manual reset request, active high |
| tsel_i | input | 2 | Timeout select |
| main_rst_o | output | 1 | Stretched main reset, active high |
| aux_good_o | output | 2 | Synchronized good flags of rails 1 and 2 |

## Verification
The hardest case to reach is a change of select, or a second cause of reset, landing in the middle of a running timeout. The result there depends on exactly which cycle the select was captured, and on the count being cleared rather than continued. The bench drives all inputs on falling edges and counts rising edges from each stimulus. It waits a known number of edges into the timeout before it changes `tsel_i`, pulses `mr_i` again or drops the main rail, and then checks the exact edge on which `main_rst_o` falls. The timeout parameters are reduced so that every select value can be run to completion.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NUM_RAIL = 3;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sup_rst_debounce.sv
module sup_rst_debounce #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic ok_o
);
  localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          ok_q;
  logic [CW-1:0] cnt_q;

  // ok_q flips only after DEPTH consecutive samples that disagree with it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else if (s_i == ok_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DEPTH - 1)) begin
      ok_q  <= s_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TMO0  = 1024,
  parameter int unsigned TMO1  = 4096,
  parameter int unsigned TMO2  = 16384,
  parameter int unsigned TMO3  = 65536
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          trig_i,
  input  logic [sup_rst_pkg::SEL_W-1:0] tsel_i,
  output logic                          rst_o,
  output logic [CNT_W-1:0]              lim_o
);
  logic [CNT_W-1:0] lut_lim;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rst_q;

  always_comb begin
    unique case (tsel_i)
      2'd0:    lut_lim = CNT_W'(TMO0 - 1);
      2'd1:    lut_lim = CNT_W'(TMO1 - 1);
      2'd2:    lut_lim = CNT_W'(TMO2 - 1);
      default: lut_lim = CNT_W'(TMO3 - 1);
    endcase
  end

  // select captured while held; frozen once counting starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
      lim_q <= CNT_W'(TMO1 - 1);
    end else if (trig_i) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
      lim_q <= lut_lim;
    end else if (rst_q) begin
      if (cnt_q == lim_q) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_o = rst_q;
  assign lim_o = lim_q;
endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_DEPTH   = 4,
  parameter int unsigned TMO0        = 1024,
  parameter int unsigned TMO1        = 4096,
  parameter int unsigned TMO2        = 16384,
  parameter int unsigned TMO3        = 65536
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [sup_rst_pkg::NUM_RAIL-1:0] rail_good_i,
  input  logic                            mr_i,
  input  logic [sup_rst_pkg::SEL_W-1:0]   tsel_i,
  output logic                            main_rst_o,
  output logic [sup_rst_pkg::NUM_RAIL-2:0] aux_good_o
);
  localparam int unsigned TMO_MAX = sup_rst_pkg::max4(TMO0, TMO1, TMO2, TMO3);
  localparam int unsigned CNT_W   = (TMO_MAX > 2) ? $clog2(TMO_MAX) : 1;
  localparam int unsigned SW      = sup_rst_pkg::NUM_RAIL + 1;

  logic [SW-1:0]    sync_q;
  logic             main_ok;
  logic             mr_s;
  logic             trig;
  logic [CNT_W-1:0] lim;

  sup_rst_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mr_i, rail_good_i}),
    .q_o   (sync_q)
  );

  sup_rst_debounce #(.DEPTH(DEB_DEPTH)) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .s_i   (sync_q[0]),
    .ok_o  (main_ok)
  );

  assign mr_s       = sync_q[SW-1];
  assign trig       = ~main_ok | mr_s;
  assign aux_good_o = sync_q[sup_rst_pkg::NUM_RAIL-1:1];

  sup_rst_timer #(
    .CNT_W(CNT_W), .TMO0(TMO0), .TMO1(TMO1), .TMO2(TMO2), .TMO3(TMO3)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig),
    .tsel_i(tsel_i),
    .rst_o (main_rst_o),
    .lim_o (lim)
  );
endmodule

// File: rtl/sup_rst_seq_chk.sv
module sup_rst_seq_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       rail_good_i,
  input logic [1:0]       aux_good_o,
  input logic             main_rst_o,
  input logic             trig_i,
  input logic             main_ok_i,
  input logic             s0_i,
  input logic [CNT_W-1:0] lim_i
);
  logic [1:0]     age_q;
  logic [CNT_W:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      run_q <= '0;
    end else begin
      if (age_q != 2'd2) age_q <= age_q + 1'b1;
      if (trig_i) run_q <= '0;
      else if (main_rst_o) run_q <= run_q + 1'b1;
    end
  end

  assert_aux_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (aux_good_o == $past(rail_good_i[2:1], 2)));

  assert_deb_agree_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(main_ok_i) |-> (main_ok_i == $past(s0_i)));

  assert_trig_holds_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> main_rst_o);

  assert_fall_after_timeout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_rst_o) |-> (run_q == ({1'b0, lim_i} + 1'b1)));
endmodule

bind sup_rst_seq sup_rst_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rail_good_i(rail_good_i),
  .aux_good_o (aux_good_o),
  .main_rst_o (main_rst_o),
  .trig_i     (trig),
  .main_ok_i  (main_ok),
  .s0_i       (sync_q[0]),
  .lim_i      (lim)
);

// File: tb/sup_rst_seq_tb_top.sv
`timescale 1ns/1ps
module sup_rst_seq_tb_top;
  localparam int T0 = 16, T1 = 32, T2 = 48, T3 = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rail = 3'b111;
  logic       mr = 1'b0;
  logic [1:0] tsel = 2'd1;
  logic       main_rst;
  logic [1:0] aux;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sup_rst_seq #(.TMO0(T0), .TMO1(T1), .TMO2(T2), .TMO3(T3)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rail_good_i(rail),
    .mr_i       (mr),
    .tsel_i     (tsel),
    .main_rst_o (main_rst),
    .aux_good_o (aux)
  );

  function automatic int tmo(int s);
    case (s)
      0: return T0;
      1: return T1;
      2: return T2;
      default: return T3;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_fall(int exp, string req);
    int n = 0;
    while (n < exp + 8 && main_rst) begin
      @(posedge clk); #1; n++;
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic measure_rise(int exp, string req);
    int n = 0;
    while (n < exp + 8 && !main_rst) begin
      @(posedge clk); #1; n++;
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic t_reset_powerup();
    repeat (3) @(posedge clk);
    #1;
    check(main_rst == 1'b1, "R1 main_rst in reset", main_rst, 1);
    check(aux == 2'b00, "R1 aux in reset", aux, 0);
    @(negedge clk); rst_n = 1'b1;
    measure_fall(6 + T1, "R7 power-up release, R8 tsel=1");
  endtask

  task automatic t_aux();
    @(negedge clk); rail[1] = 1'b0;
    @(posedge clk); #1;
    check(aux[0] == 1'b1, "R2 aux0 one edge", aux[0], 1);
    @(posedge clk); #1;
    check(aux[0] == 1'b0, "R2 aux0 two edges", aux[0], 0);
    @(negedge clk); rail[2] = 1'b0; rail[1] = 1'b1;
    repeat (2) @(posedge clk); #1;
    check(aux == 2'b01, "R2 aux pattern", aux, 1);
    check(main_rst == 1'b0, "R2 main unaffected", main_rst, 0);
    @(negedge clk); rail[2] = 1'b1;
    repeat (2) @(posedge clk); #1;
    check(aux == 2'b11, "R2 aux restored", aux, 3);
  endtask

  task automatic t_glitch();
    int hi = 0;
    @(negedge clk); rail[0] = 1'b0;
    repeat (3) @(negedge clk);
    rail[0] = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (main_rst) hi++;
    end
    check(hi == 0, "R4 short low pulse ignored", hi, 0);
  endtask

  task automatic t_rail_drop();
    @(negedge clk); rail[0] = 1'b0;
    measure_rise(7, "R3 rail loss assert");
    repeat (5) @(negedge clk);
    rail[0] = 1'b1;
    measure_fall(6 + T1, "R7 rail recovery");
  endtask

  task automatic t_mr(int s);
    @(negedge clk); mr = 1'b1; tsel = 2'(s);
    measure_rise(3, "R5 manual assert");
    repeat (3) @(negedge clk);
    mr = 1'b0;
    measure_fall(2 + tmo(s), $sformatf("R6 R8 manual release tsel=%0d", s));
  endtask

  task automatic t_restart();
    @(negedge clk); mr = 1'b1; tsel = 2'd0;
    repeat (4) @(negedge clk);
    mr = 1'b0;
    repeat (10) @(negedge clk);
    check(main_rst == 1'b1, "R9 held mid timeout", main_rst, 1);
    mr = 1'b1;
    repeat (2) @(negedge clk);
    mr = 1'b0;
    measure_fall(2 + T0, "R9 manual restart full count");
    @(negedge clk); mr = 1'b1;
    repeat (4) @(negedge clk);
    mr = 1'b0;
    repeat (6) @(negedge clk);
    rail[0] = 1'b0;
    repeat (8) @(negedge clk);
    check(main_rst == 1'b1, "R9 held on rail loss", main_rst, 1);
    rail[0] = 1'b1;
    measure_fall(6 + T0, "R9 rail restart full count");
  endtask

  task automatic t_sel_change();
    @(negedge clk); mr = 1'b1; tsel = 2'd0;
    repeat (4) @(negedge clk);
    mr = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); tsel = 2'd3;
    measure_fall(2 + T0 - 5, "R10 mid-count select ignored");
    @(negedge clk); mr = 1'b1;
    repeat (4) @(negedge clk);
    mr = 1'b0;
    measure_fall(2 + T3, "R10 select applies next time");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_powerup();
    t_aux();
    t_glitch();
    t_rail_drop();
    for (int s = 0; s < 4; s++) t_mr(s);
    t_restart();
    t_sel_change();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule